// File: doc/BRIEF.md
# Oscillator Period Capture Timer

This block is a free-running up-counter clocked by a trusted reference clock, with a capture path that measures the period of a slower clock. The slower clock has no fixed phase relation to the reference. It passes through a synchronizer and then an edge detector. On every qualifying edge, the whole counter value is copied into one capture register in a single cycle, and a sticky flag is raised.

Each instance is built to trigger on one edge polarity only, either rising or falling. Software reads two successive captures and subtracts them modulo 2^CNT_W. The result is the slow clock's period in reference ticks. The capture register doubles as an ordinary read/write register, so software can preload it when captures are not in use.

Top module: `osc_capture_timer`

## Requirements
- R1: While `rst` is high, and on the first sample after it, `count_q`, `capture_q` and `capture_flag` are all zero.
- R2: `count_q` increases by exactly one on every reference clock edge where `run_en` is high. It holds its value where `run_en` is low.
- R3: `count_q` wraps from all ones (0xFFFF at the default width) to zero and keeps counting.
- R4: When `lf_clk` changes towards the configured edge just before reference edge E0, `capture_q` is unchanged after edge E1. After edge E2 it holds the counter value from between E1 and E2, which is the count seen before E0 plus SYNC_STAGES. `capture_flag` is set at E2, and the whole register is updated in that one cycle.
- R5: An edge of the opposite polarity produces no capture and does not set `capture_flag`.
- R6: For a periodic `lf_clk` with a period of P reference cycles, the difference of two successive captures, taken modulo 2^CNT_W, equals P. This also holds when the counter wraps between the two captures.
- R7: `capture_flag` stays set until a cycle with `flag_clr` high clears it. If a capture and `flag_clr` occur in the same cycle, the flag remains set.
- R8: While `run_en` is low or `cap_mode` is low, edges on `lf_clk` leave `capture_q` and `capture_flag` unchanged.
- R9: With `wr_en` high, `capture_q` loads `wr_data` on the next edge. If a capture occurs in the same cycle, the captured count is loaded instead of `wr_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock (known time base) |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Counter run enable; captures are only accepted while high |
| cap_mode | input | 1 | Selects capture mode; captures are only accepted while high |
| lf_clk | input | 1 | Slow clock under measurement, asynchronous to `clk` |
| wr_en | input | 1 | Software write strobe for the capture/reload register |
| wr_data | input | CNT_W | Software write data |
| flag_clr | input | 1 | Clears the capture flag |
| count_q | output | CNT_W | Running counter value |
| capture_q | output | CNT_W | Capture/reload register |
| capture_flag | output | 1 | Sticky flag, set by each capture |

## Verification
The bench builds two copies at the default 16-bit width and a two-stage synchronizer. One copy is set to the rising edge and the other to the falling edge, and both are driven by the same slow clock. Every slow-clock edge therefore tests capture on one copy and rejection on the other. Using the full 16-bit width makes the natural wrap reachable within the run. A slow-clock period is placed across that wrap to test the modulo difference. Because the synchronizer depth is two, the exact capture cycle is fixed at three reference edges after the slow edge is driven.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } edge_sel_e;

  // Edge test on two successive synchronized samples.
  function automatic logic edge_seen(input logic prev, input logic cur,
                                     input edge_sel_e sel);
    if (sel == EDGE_RISE) return cur & ~prev;
    else                  return prev & ~cur;
  endfunction

endpackage

// File: rtl/ocp_sync.sv
module ocp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic sync_o
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= (chain << 1) | STAGES'(async_i);
  end

  assign sync_o = chain[STAGES-1];

endmodule

// File: rtl/ocp_edge_det.sv
module ocp_edge_det
  import ocp_pkg::*;
#(
  parameter edge_sel_e EDGE   = EDGE_RISE,
  parameter int        SETTLE = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic level_i,
  output logic pulse_o
);

  localparam int SW = $clog2(SETTLE + 1);

  logic          prev;
  logic [SW-1:0] settle_cnt;
  logic          armed;

  // Edges are masked until the synchronizer chain has filled with real samples.
  assign armed = (settle_cnt == SW'(SETTLE));

  always_ff @(posedge clk) begin
    if (rst) begin
      prev       <= 1'b0;
      settle_cnt <= '0;
    end else begin
      prev <= level_i;
      if (!armed) settle_cnt <= settle_cnt + 1'b1;
    end
  end

  assign pulse_o = armed & edge_seen(prev, level_i, EDGE);

endmodule

// File: rtl/ocp_counter.sv
module ocp_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  output logic [W-1:0] count_o
);

  always_ff @(posedge clk) begin
    if (rst)     count_o <= '0;
    else if (en) count_o <= count_o + 1'b1;
  end

endmodule

// File: rtl/osc_capture_timer.sv
module osc_capture_timer
  import ocp_pkg::*;
#(
  parameter int        CNT_W        = 16,
  parameter int        SYNC_STAGES  = 2,
  parameter edge_sel_e CAPTURE_EDGE = EDGE_RISE
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_en,
  input  logic             cap_mode,
  input  logic             lf_clk,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] count_q,
  output logic [CNT_W-1:0] capture_q,
  output logic             capture_flag
);

  localparam int SETTLE = SYNC_STAGES + 1;

  logic lf_sync;
  logic edge_hit;
  logic cap_fire;

  ocp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (lf_clk),
    .sync_o  (lf_sync)
  );

  ocp_edge_det #(.EDGE(CAPTURE_EDGE), .SETTLE(SETTLE)) u_edge (
    .clk     (clk),
    .rst     (rst),
    .level_i (lf_sync),
    .pulse_o (edge_hit)
  );

  ocp_counter #(.W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .en      (run_en),
    .count_o (count_q)
  );

  assign cap_fire = edge_hit & run_en & cap_mode;

  // Whole-word load: capture beats a software write.
  always_ff @(posedge clk) begin
    if (rst)           capture_q <= '0;
    else if (cap_fire) capture_q <= count_q;
    else if (wr_en)    capture_q <= wr_data;
  end

  // Sticky flag: a capture beats a clear.
  always_ff @(posedge clk) begin
    if (rst)           capture_flag <= 1'b0;
    else if (cap_fire) capture_flag <= 1'b1;
    else if (flag_clr) capture_flag <= 1'b0;
  end

endmodule

// File: rtl/osc_capture_timer_chk.sv
module osc_capture_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             run_en,
  input logic             cap_mode,
  input logic             wr_en,
  input logic [CNT_W-1:0] wr_data,
  input logic             flag_clr,
  input logic             cap_fire,
  input logic [CNT_W-1:0] count_q,
  input logic [CNT_W-1:0] capture_q,
  input logic             capture_flag
);

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    run_en |=> count_q == CNT_W'($past(count_q) + 1'b1)); // R2
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> $stable(count_q)); // R2
  AST_COUNT_WRAP: assert property (@(posedge clk) disable iff (rst)
    (run_en && count_q == {CNT_W{1'b1}}) |=> count_q == '0); // R3
  AST_CAPTURE_LOAD: assert property (@(posedge clk) disable iff (rst)
    cap_fire |=> (capture_q == $past(count_q)) && capture_flag); // R4
  AST_CAPTURE_GATED: assert property (@(posedge clk) disable iff (rst)
    !(run_en && cap_mode) |-> !cap_fire); // R8
  AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!cap_fire && !wr_en) |=> $stable(capture_q)); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (capture_flag && !flag_clr) |=> capture_flag); // R7
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (flag_clr && !cap_fire) |=> !capture_flag); // R7
  AST_WRITE_LOAD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !cap_fire) |=> capture_q == $past(wr_data)); // R9

endmodule

bind osc_capture_timer osc_capture_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .run_en       (run_en),
  .cap_mode     (cap_mode),
  .wr_en        (wr_en),
  .wr_data      (wr_data),
  .flag_clr     (flag_clr),
  .cap_fire     (cap_fire),
  .count_q      (count_q),
  .capture_q    (capture_q),
  .capture_flag (capture_flag)
);

// File: tb/sim_osc_capture_timer.sv
module sim_osc_capture_timer;
  import ocp_pkg::*;

  localparam int W = 16;
  localparam int NV = 6;
  localparam int HI_T[NV] = '{2, 3, 5, 10, 40, 2};
  localparam int LO_T[NV] = '{2, 4, 5, 7, 25, 9};

  logic clk = 1'b0, rst = 1'b1, run_en = 1'b0, cap_mode = 1'b0;
  logic lf_clk = 1'b0, wr_en = 1'b0, flag_clr = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] c0, q0, c1, q1;
  logic f0, f1;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  osc_capture_timer #(.CNT_W(W), .SYNC_STAGES(2), .CAPTURE_EDGE(EDGE_RISE)) u0 (
    .clk(clk), .rst(rst), .run_en(run_en), .cap_mode(cap_mode), .lf_clk(lf_clk),
    .wr_en(wr_en), .wr_data(wr_data), .flag_clr(flag_clr),
    .count_q(c0), .capture_q(q0), .capture_flag(f0));

  osc_capture_timer #(.CNT_W(W), .SYNC_STAGES(2), .CAPTURE_EDGE(EDGE_FALL)) u1 (
    .clk(clk), .rst(rst), .run_en(run_en), .cap_mode(cap_mode), .lf_clk(lf_clk),
    .wr_en(wr_en), .wr_data(wr_data), .flag_clr(flag_clr),
    .count_q(c1), .capture_q(q1), .capture_flag(f1));

  // Capture history seen at the ports.
  logic [W-1:0] last0 = '0, prev0 = '0, last1 = '0, prev1 = '0;
  always @(negedge clk) begin
    if (q0 != last0) begin prev0 = last0; last0 = q0; end
    if (q1 != last1) begin prev1 = last1; last1 = q1; end
  end

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%h expected 0x%h", req, act, exp);
    end
  endtask

  task automatic nwait(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic slow_period(input int hi, input int lo);
    lf_clk = 1'b1; nwait(hi);
    lf_clk = 1'b0; nwait(lo);
  endtask

  task automatic pulse_clr();
    flag_clr = 1'b1; nwait(1); flag_clr = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [W-1:0] base, held0, held1, hold_c, pc;
    bit seen_wrap;

    // R1 reset state
    nwait(3);
    chk("R1 count", c0, '0);
    chk("R1 capture", q0, '0);
    chk("R1 flag", {15'b0, f0 | f1}, '0);
    rst = 1'b0;
    nwait(5);
    chk("R1 count after release", c0, '0);

    // R2 hold while stopped, then count
    chk("R2 hold", c0, '0);
    run_en = 1'b1;
    base = c0;
    nwait(10);
    chk("R2 step", c0, base + 16'd10);

    // R4 latency and value, R5 opposite edge ignored
    cap_mode = 1'b1;
    base = c0;
    lf_clk = 1'b1;
    nwait(2);
    chk("R4 not yet captured", q0, '0);
    nwait(1);
    chk("R4 capture value", q0, base + 16'd2);
    chk("R4 flag set", {15'b0, f0}, 16'd1);
    chk("R5 falling instance ignores rise", q1, '0);
    chk("R5 falling instance flag", {15'b0, f1}, '0);

    // R7 clear, then capture wins over clear
    pulse_clr();
    chk("R7 clear", {15'b0, f0}, '0);
    base = c0;
    lf_clk = 1'b0;
    nwait(2);
    flag_clr = 1'b1;
    nwait(1);
    flag_clr = 1'b0;
    chk("R7 capture beats clear", {15'b0, f1}, 16'd1);
    chk("R4 falling capture value", q1, base + 16'd2);
    chk("R7 flag stays clear", {15'b0, f0}, '0);
    pulse_clr();
    chk("R7 clear falling", {15'b0, f1}, '0);

    // R6 period table
    for (int i = 0; i < NV; i++) begin
      for (int k = 0; k < 4; k++) slow_period(HI_T[i], LO_T[i]);
      nwait(4);
      chk("R6 rising period", last0 - prev0, 16'(HI_T[i] + LO_T[i]));
      chk("R6 falling period", last1 - prev1, 16'(HI_T[i] + LO_T[i]));
    end

    // R8 stopped timer ignores edges
    pulse_clr();
    run_en = 1'b0;
    nwait(1);
    hold_c = c0; held0 = q0; held1 = q1;
    lf_clk = 1'b1; nwait(6);
    lf_clk = 1'b0; nwait(6);
    chk("R8 stopped rising capture", q0, held0);
    chk("R8 stopped falling capture", q1, held1);
    chk("R8 stopped flags", {14'b0, f1, f0}, '0);
    chk("R2 stopped count", c0, hold_c);
    run_en = 1'b1;
    nwait(2);

    // R8 capture mode off ignores edges
    cap_mode = 1'b0;
    held0 = q0; held1 = q1;
    lf_clk = 1'b1; nwait(6);
    lf_clk = 1'b0; nwait(6);
    chk("R8 mode off rising capture", q0, held0);
    chk("R8 mode off falling capture", q1, held1);
    chk("R8 mode off flags", {14'b0, f1, f0}, '0);
    cap_mode = 1'b1;
    nwait(2);

    // R9 software write, then capture beats write
    wr_data = 16'hBEEF; wr_en = 1'b1; nwait(1); wr_en = 1'b0;
    chk("R9 write", q0, 16'hBEEF);
    base = c0;
    lf_clk = 1'b1;
    nwait(2);
    wr_data = 16'h1111; wr_en = 1'b1;
    nwait(1);
    wr_en = 1'b0;
    chk("R9 capture beats write", q0, base + 16'd2);
    chk("R9 write lands without capture", q1, 16'h1111);
    lf_clk = 1'b0;
    nwait(4);

    // R3 wrap, R6 period across the wrap
    for (int i = 0; i < 70000; i++) begin
      @(negedge clk);
      if (c0 == 16'hFFF0) break;
    end
    seen_wrap = 0;
    for (int i = 0; i < 30; i++) begin
      lf_clk = ((i % 20) < 10);
      pc = c0;
      @(negedge clk);
      if (pc == 16'hFFFF) begin
        seen_wrap = 1;
        chk("R3 wrap", c0, '0);
      end
    end
    if (!seen_wrap) chk("R3 wrap reached", 16'd0, 16'd1);
    lf_clk = 1'b0;
    nwait(4);
    chk("R6 rising period across wrap", last0 - prev0, 16'd20);
    chk("R6 falling period across wrap", last1 - prev1, 16'd20);

    done = 1;
    summary();
    $finish;
  end

endmodule